// File: doc/BRIEF.md
# Table-Driven Register Initialisation Sequencer

The sequencer replays a read-only list of two-word configuration commands onto a simple 32-bit register bus. A go strobe starts it with a half-open index window [start, end). It fetches each command in index order and folds variant-specific and platform-specific opcodes onto a small common set. It then issues one bus access, or a run of word accesses, for each command it keeps. Commands meant for other silicon, commands of length zero and commands it does not support are passed over without touching the bus.

Command and data tables sit outside the block. The sequencer drives an index to each table and reads back the addressed word in the same cycle. Every bus beat is held until the target raises ready. Long runs are marked in chunks of a fixed maximum burst length. A one-cycle done pulse reports that the window has been fully processed.

Top module: `reg_init_sequencer`

## Requirements
- R1: After reset, bus_req and done are low, and neither rises until go is strobed.
- R2: Word 0 of a command carries the opcode in bits [31:24] and the register byte offset in bits [23:0]. For a plain write (opcode 2), word 1 is the value written to that offset.
- R3: Opcode 1 makes one read access (bus_we=0). Opcode 3 is a write with bus_ind=1. Opcode 6 writes zero to word1 consecutive words. Opcode 7, opcode 0 and any opcode above 0x1F make no access.
- R4: Opcodes 4 and 9 copy N words and opcode 5 does the same with bus_ind=1. Word 1 holds N in bits [31:16] and a data-table index D in bits [15:0]. Word k comes from data entry D+k and is written to offset+4k.
- R5: Opcode 8 writes 2N words, with N in word1[31:16]. Even beats carry data entry D (the low half) and odd beats carry entry D+1 (the high half), so the low half always lands at the lower address.
- R6: Opcodes 0x0A-0x12 act as opcode minus 9 when variant_b=0. Opcodes 0x13-0x1B act as opcode minus 18 when variant_b=1. In every other case these opcodes are skipped.
- R7: Platform code 0 is emulation, 1 is prototype and 2 is production silicon. Opcodes 0x1D, 0x1E and 0x1F act as a plain write only on platform 0, 1 and 2 respectively. Opcode 0x1C acts as a write only on platform 0 with variant_b=1. Otherwise all four are skipped.
- R8: Commands are executed strictly in index order, and a command with a zero word count makes no access. When start >= end, done is raised with no access at all.
- R9: While bus_req is high and bus_ready is low, bus_req, bus_addr, bus_wdata and bus_we hold their values into the next cycle.
- R10: bus_burst_start is high on beat 0 of each command and on every MAX_BURST-th beat after it.
- R11: done is a single-cycle pulse, raised once per go, after the last beat of the window. A go that arrives while a window is in progress is ignored, and the window bounds are taken at go.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start strobe, sampled only while idle |
| start_idx | input | IDX_W | First command index |
| end_idx | input | IDX_W | One past the last command index |
| variant_b | input | 1 | Silicon variant select (0 = A, 1 = B) |
| platform | input | 2 | 0 emulation, 1 prototype, 2 production |
| cmd_idx | output | IDX_W | Index into the command table |
| cmd_word0 | input | 32 | Opcode and offset word at cmd_idx |
| cmd_word1 | input | 32 | Argument word at cmd_idx |
| dat_idx | output | 16 | Index into the data table |
| dat_word | input | 32 | Data word at dat_idx |
| bus_req | output | 1 | Access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_ind | output | 1 | Access goes through the indirect path |
| bus_burst_start | output | 1 | First beat of a chunk |
| bus_addr | output | 32 | Byte address |
| bus_wdata | output | 32 | Write data |
| bus_ready | input | 1 | Target accepts the current beat |
| done | output | 1 | Window finished (one-cycle pulse) |

## Verification
A wrong fold of an opcode shows up as an extra or a missing access at the very handshake where the command's beats were expected. The reference model queues every beat in order, so the mismatch is reported in that cycle. A beat counter or data index that drifts shows up as a wrong address or a wrong data word on the next accepted beat. A miscounted chunk shows up as a misplaced burst-start flag. Stalling ready at irregular points exposes a request that changes before it is accepted within one cycle. A broken end condition shows up either as a missing done, which the bench catches with a timeout, or as stray accesses after done.

// File: rtl/rinit_pkg.sv
package rinit_pkg;

   typedef enum logic [2:0] {
      K_SKIP    = 3'd0,
      K_READ    = 3'd1,
      K_WRITE   = 3'd2,
      K_STRING  = 3'd3,
      K_ZERO    = 3'd4,
      K_PATTERN = 3'd5
   } kind_e;

   localparam logic [7:0] OPC_LAST_COMMON = 8'h09;
   localparam logic [7:0] OPC_LAST_VAR_A  = 8'h12;
   localparam logic [7:0] OPC_LAST_VAR_B  = 8'h1B;
   localparam logic [7:0] OPC_EMU_VAR_B   = 8'h1C;
   localparam logic [7:0] OPC_ONLY_EMU    = 8'h1D;
   localparam logic [7:0] OPC_ONLY_PROTO  = 8'h1E;
   localparam logic [7:0] OPC_ONLY_SILI   = 8'h1F;

   // Folds variant and platform opcodes onto the common set.
   // The variant step runs before the platform step.
   function automatic logic [7:0] fold_op(input logic [7:0] op,
                                          input logic var_b,
                                          input logic [1:0] plat);
      logic [7:0] t;
      t = op;
      if (t > OPC_LAST_COMMON) begin
         if (t <= OPC_LAST_VAR_A) begin
            if (!var_b) t = t - 8'd9;
         end else if (t <= OPC_LAST_VAR_B) begin
            if (var_b) t = t - 8'd18;
         end
         if ((t == OPC_ONLY_EMU && plat == 2'd0) ||
             (t == OPC_ONLY_PROTO && plat == 2'd1) ||
             (t == OPC_ONLY_SILI && plat == 2'd2))
            t = 8'h02;
         if (t == OPC_EMU_VAR_B && plat == 2'd0 && var_b)
            t = 8'h02;
      end
      return t;
   endfunction

endpackage

// File: rtl/rinit_decode.sv
module rinit_decode #(
   parameter int CNT_W = 32
) (
   input  logic [31:0]         word0,
   input  logic [31:0]         word1,
   input  logic                var_b,
   input  logic [1:0]          plat,
   output rinit_pkg::kind_e    kind,
   output logic                ind,
   output logic [CNT_W-1:0]    count,
   output logic [15:0]         dbase,
   output logic [23:0]         offset
);
   import rinit_pkg::*;

   logic [7:0]  op_f;
   logic [15:0] n_field;

   assign op_f    = fold_op(word0[31:24], var_b, plat);
   assign n_field = word1[31:16];
   assign dbase   = word1[15:0];
   assign offset  = word0[23:0];

   always_comb begin
      kind  = K_SKIP;
      ind   = 1'b0;
      count = '0;
      case (op_f)
         8'h01: begin kind = K_READ;  count = CNT_W'(1); end
         8'h02: begin kind = K_WRITE; count = CNT_W'(1); end
         8'h03: begin kind = K_WRITE; count = CNT_W'(1); ind = 1'b1; end
         8'h04,
         8'h09: begin kind = K_STRING; count = CNT_W'(n_field); end
         8'h05: begin kind = K_STRING; count = CNT_W'(n_field); ind = 1'b1; end
         8'h06: begin kind = K_ZERO;   count = word1[CNT_W-1:0]; end
         8'h08: begin kind = K_PATTERN; count = CNT_W'({n_field, 1'b0}); end
         default: ;
      endcase
      if (count == '0) kind = K_SKIP;
   end

endmodule

// File: rtl/rinit_beats.sv
module rinit_beats #(
   parameter int CNT_W     = 32,
   parameter int MAX_BURST = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   output logic [CNT_W-1:0] beat,
   output logic             first
);
   localparam int CH_W = (MAX_BURST > 1) ? $clog2(MAX_BURST) : 1;
   localparam bit POW2 = ((MAX_BURST & (MAX_BURST - 1)) == 0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    beat <= '0;
      else if (load) beat <= '0;
      else if (step) beat <= beat + CNT_W'(1);
   end

   generate
      if (MAX_BURST < 2) begin : g_bad
         $error("MAX_BURST must be at least 2");
      end
      if (POW2) begin : g_pow2
         assign first = (beat[CH_W-1:0] == '0);
      end else begin : g_cnt
         logic [CH_W-1:0] ch;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    ch <= '0;
            else if (load) ch <= '0;
            else if (step) ch <= (ch == CH_W'(MAX_BURST - 1)) ? '0 : ch + CH_W'(1);
         end
         assign first = (ch == '0);
      end
   endgenerate

   // R10
   load_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (first && beat == '0));

endmodule

// File: rtl/reg_init_sequencer.sv
module reg_init_sequencer #(
   parameter int IDX_W     = 8,
   parameter int CNT_W     = 32,
   parameter int MAX_BURST = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [IDX_W-1:0] start_idx,
   input  logic [IDX_W-1:0] end_idx,
   input  logic             variant_b,
   input  logic [1:0]       platform,
   output logic [IDX_W-1:0] cmd_idx,
   input  logic [31:0]      cmd_word0,
   input  logic [31:0]      cmd_word1,
   output logic [15:0]      dat_idx,
   input  logic [31:0]      dat_word,
   output logic             bus_req,
   output logic             bus_we,
   output logic             bus_ind,
   output logic             bus_burst_start,
   output logic [31:0]      bus_addr,
   output logic [31:0]      bus_wdata,
   input  logic             bus_ready,
   output logic             done
);
   import rinit_pkg::*;

   localparam int DOFF_W = 16;

   generate
      if (CNT_W < 17 || CNT_W > 32) begin : g_bad_cnt
         $error("CNT_W must lie in 17..32");
      end
   endgenerate

   typedef enum logic [1:0] {S_IDLE, S_SCAN, S_MOVE} st_e;

   st_e               state;
   logic [IDX_W-1:0]  idx, end_r;
   kind_e             kind_r, dk;
   logic              ind_r, dind;
   logic [CNT_W-1:0]  count_r, dcount, beat;
   logic [DOFF_W-1:0] base_r, dbase;
   logic [23:0]       off_r, doff;
   logic [31:0]       wval_r, beat32;
   logic              first, last, load, step;

   rinit_decode #(.CNT_W(CNT_W)) u_dec (
      .word0(cmd_word0), .word1(cmd_word1), .var_b(variant_b), .plat(platform),
      .kind(dk), .ind(dind), .count(dcount), .dbase(dbase), .offset(doff));

   rinit_beats #(.CNT_W(CNT_W), .MAX_BURST(MAX_BURST)) u_beats (
      .clk(clk), .rst_n(rst_n), .load(load), .step(step),
      .beat(beat), .first(first));

   assign load = (state == S_SCAN) && (idx < end_r) && (dk != K_SKIP);
   assign step = (state == S_MOVE) && bus_ready;
   assign last = (beat == count_r - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         idx     <= '0;
         end_r   <= '0;
         done    <= 1'b0;
         kind_r  <= K_SKIP;
         ind_r   <= 1'b0;
         count_r <= '0;
         base_r  <= '0;
         off_r   <= '0;
         wval_r  <= '0;
      end else begin
         done <= 1'b0;
         case (state)
            S_IDLE: if (go) begin
               idx   <= start_idx;
               end_r <= end_idx;
               state <= S_SCAN;
            end
            S_SCAN: begin
               if (idx >= end_r) begin
                  done  <= 1'b1;
                  state <= S_IDLE;
               end else if (dk == K_SKIP) begin
                  idx <= idx + IDX_W'(1);
               end else begin
                  kind_r  <= dk;
                  ind_r   <= dind;
                  count_r <= dcount;
                  base_r  <= dbase;
                  off_r   <= doff;
                  wval_r  <= cmd_word1;
                  state   <= S_MOVE;
               end
            end
            S_MOVE: if (bus_ready && last) begin
               idx   <= idx + IDX_W'(1);
               state <= S_SCAN;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign cmd_idx         = idx;
   assign beat32          = 32'(beat);
   assign bus_req         = (state == S_MOVE);
   assign bus_we          = (kind_r != K_READ);
   assign bus_ind         = ind_r && bus_req;
   assign bus_burst_start = bus_req && first;
   assign bus_addr        = {8'h00, off_r} + {beat32[29:0], 2'b00};
   assign dat_idx         = base_r + ((kind_r == K_PATTERN) ? {15'd0, beat[0]} : beat[15:0]);

   always_comb begin
      case (kind_r)
         K_WRITE:             bus_wdata = wval_r;
         K_STRING, K_PATTERN: bus_wdata = dat_word;
         default:             bus_wdata = '0;
      endcase
   end

   // R9
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) &&
                                   $stable(bus_wdata) && $stable(bus_we)));
   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R11
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !bus_req);
   // R4
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_ready && !last) |=> (bus_req && bus_addr == $past(bus_addr) + 32'd4));

endmodule

// File: tb/reg_init_sequencer_test.sv
`timescale 1ns/1ps
module reg_init_sequencer_test;
   localparam int IDX_W = 6;
   localparam int MB    = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic go = 1'b0;
   logic [IDX_W-1:0] start_idx = '0, end_idx = '0;
   logic variant_b = 1'b0;
   logic [1:0] platform = 2'd2;
   logic [IDX_W-1:0] cmd_idx;
   logic [15:0] dat_idx;
   logic [31:0] cmd_word0, cmd_word1, dat_word;
   logic bus_req, bus_we, bus_ind, bus_burst_start, done;
   logic [31:0] bus_addr, bus_wdata;
   logic bus_ready = 1'b0;

   logic [31:0] cmd0 [64];
   logic [31:0] cmd1 [64];
   logic [31:0] dat  [64];

   assign cmd_word0 = cmd0[cmd_idx];
   assign cmd_word1 = cmd1[cmd_idx];
   assign dat_word  = dat[dat_idx[5:0]];

   always #2 clk = ~clk;

   reg_init_sequencer #(.IDX_W(IDX_W), .CNT_W(32), .MAX_BURST(MB)) uut (
      .clk(clk), .rst_n(rst_n), .go(go), .start_idx(start_idx), .end_idx(end_idx),
      .variant_b(variant_b), .platform(platform), .cmd_idx(cmd_idx),
      .cmd_word0(cmd_word0), .cmd_word1(cmd_word1), .dat_idx(dat_idx),
      .dat_word(dat_word), .bus_req(bus_req), .bus_we(bus_we), .bus_ind(bus_ind),
      .bus_burst_start(bus_burst_start), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_ready(bus_ready), .done(done));

   int checks = 0, errors = 0;
   int cyc = 0, rdy_mode = 0, done_cnt = 0;
   bit done_prev = 0, waiting = 0;
   logic [31:0] w_addr, w_data;

   logic [31:0] q_addr[$], q_data[$];
   bit q_we[$], q_ind[$], q_bs[$];
   string q_tag[$];

   task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic push(logic [31:0] a, logic [31:0] d, bit we, bit ind, bit bs, string tag);
      q_addr.push_back(a); q_data.push_back(d); q_we.push_back(we);
      q_ind.push_back(ind); q_bs.push_back(bs); q_tag.push_back(tag);
   endtask

   task automatic put(int i, logic [7:0] op, logic [23:0] off, logic [31:0] w1);
      cmd0[i] = {op, off};
      cmd1[i] = w1;
   endtask

   // Behavioural expectation of the beats for one window
   task automatic build(int s, int e, bit vb, logic [1:0] pl);
      for (int i = s; i < e; i++) begin
         int op, eff, len, base;
         logic [31:0] off, w1;
         string tag;
         op = int'(cmd0[i][31:24]); off = {8'h00, cmd0[i][23:0]}; w1 = cmd1[i];
         len = int'(w1[31:16]); base = int'(w1[15:0]);
         eff = op;
         if (op >= 10 && op <= 18) eff = vb ? 0 : op - 9;
         else if (op >= 19 && op <= 27) eff = vb ? op - 18 : 0;
         else if (op == 28) eff = (vb && pl == 2'd0) ? 2 : 0;
         else if (op >= 29 && op <= 31) eff = (int'(pl) == op - 29) ? 2 : 0;
         else if (op > 31) eff = 0;
         if (op >= 10 && op <= 27) tag = "R6";
         else if (op >= 28) tag = "R7";
         else if (eff == 2) tag = "R2";
         else if (eff == 4 || eff == 5 || eff == 9) tag = "R4";
         else if (eff == 8) tag = "R5";
         else tag = "R3";
         case (eff)
            1: push(off, 32'h0, 0, 0, 1, tag);
            2, 3: push(off, w1, 1, eff == 3, 1, tag);
            4, 5, 9: for (int k = 0; k < len; k++)
               push(off + 4*k, dat[(base + k) % 64], 1, eff == 5, (k % MB) == 0, tag);
            6: for (int k = 0; k < int'(w1); k++)
               push(off + 4*k, 32'h0, 1, 0, (k % MB) == 0, tag);
            8: for (int k = 0; k < 2*len; k++)
               push(off + 4*k, dat[(base + (k % 2)) % 64], 1, 0, (k % MB) == 0, tag);
            default: ;
         endcase
      end
   endtask

   // Ready driver and per-cycle monitor
   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         bus_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 1 && (cyc % 7) != 2);
         #1;
         if (rst_n) begin
            if (waiting)
               check(bus_req && bus_addr == w_addr && bus_wdata == w_data, "R9",
                     "stalled beat changed", bus_addr, w_addr);
            waiting = bus_req && !bus_ready;
            w_addr = bus_addr; w_data = bus_wdata;
            if (bus_req && bus_ready) begin
               if (q_addr.size() == 0) begin
                  check(0, "R8", "unexpected access", bus_addr, 32'h0);
               end else begin
                  logic [31:0] ea, ed; bit ew, ei, eb; string tg;
                  ea = q_addr.pop_front(); ed = q_data.pop_front(); ew = q_we.pop_front();
                  ei = q_ind.pop_front(); eb = q_bs.pop_front(); tg = q_tag.pop_front();
                  check(bus_addr == ea && bus_we == ew && bus_ind == ei &&
                        (!ew || bus_wdata == ed), tg, "beat addr", bus_addr, ea);
                  if (ew)
                     check(bus_wdata == ed, tg, "beat data", bus_wdata, ed);
                  check(bus_burst_start == eb, "R10", "burst start", 32'(bus_burst_start), 32'(eb));
               end
            end
            if (done) begin
               done_cnt++;
               if (done_prev) check(0, "R11", "done wider than one cycle", 1, 0);
            end
            done_prev = done;
         end
      end
   end

   task automatic run(int s, int e, bit vb, logic [1:0] pl, int rmode, bit regos);
      int t;
      build(s, e, vb, pl);
      @(negedge clk);
      variant_b = vb; platform = pl; rdy_mode = rmode; done_cnt = 0;
      start_idx = IDX_W'(s); end_idx = IDX_W'(e); go = 1'b1;
      @(negedge clk); go = 1'b0;
      if (regos) begin
         repeat (4) @(negedge clk);
         start_idx = '0; end_idx = IDX_W'(20); go = 1'b1;
         @(negedge clk); go = 1'b0;
      end
      t = 0;
      while (done_cnt == 0 && t < 3000) begin @(negedge clk); t++; end
      if (t >= 3000) check(0, "R11", "watchdog: no done", 0, 1);
      repeat (10) @(negedge clk);
      check(done_cnt == 1, "R11", "done pulses per go", done_cnt, 1);
      check(q_addr.size() == 0, "R8", "beats left unissued", q_addr.size(), 0);
      q_addr.delete(); q_data.delete(); q_we.delete();
      q_ind.delete(); q_bs.delete(); q_tag.delete();
   endtask

   initial begin
      #700000;
      check(0, "R11", "global watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int k = 0; k < 64; k++) begin
         dat[k] = 32'hD000_0000 + 32'(k) * 32'h111;
         cmd0[k] = 32'h0; cmd1[k] = 32'h0;
      end
      put(0,  8'h01, 24'h000100, 32'h0);
      put(1,  8'h02, 24'h000104, 32'hA5A5_0001);
      put(2,  8'h03, 24'h000108, 32'h1234_5678);
      put(3,  8'h04, 24'h000200, {16'd5, 16'd0});
      put(4,  8'h06, 24'h000300, 32'd4);
      put(5,  8'h08, 24'h000400, {16'd2, 16'd10});
      put(6,  8'h07, 24'h000500, {16'd1, 16'd0});
      put(7,  8'h00, 24'h000504, 32'h0);
      put(8,  8'h0B, 24'h000600, 32'hBEEF_000B);
      put(9,  8'h14, 24'h000604, 32'hBEEF_0014);
      put(10, 8'h1F, 24'h000608, 32'h1F1F_1F1F);
      put(11, 8'h1D, 24'h00060C, 32'h1D1D_1D1D);
      put(12, 8'h1C, 24'h000610, 32'h1C1C_1C1C);
      put(13, 8'h04, 24'h000700, {16'd0, 16'd20});
      put(14, 8'h25, 24'h000704, 32'hFFFF_FFFF);
      put(15, 8'h05, 24'h000800, {16'd2, 16'd20});
      put(16, 8'h09, 24'h000900, {16'd1, 16'd30});
      put(17, 8'h0D, 24'h000A00, {16'd2, 16'd40});
      put(18, 8'h16, 24'h000B00, {16'd2, 16'd42});
      put(19, 8'h1E, 24'h000C00, 32'h1E1E_1E1E);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      // R1 reset state
      check(bus_req == 1'b0, "R1", "bus_req after reset", 32'(bus_req), 0);
      check(done == 1'b0, "R1", "done after reset", 32'(done), 0);

      run(0, 20, 1'b0, 2'd2, 0, 1'b0);   // variant A, production silicon
      run(0, 20, 1'b1, 2'd0, 1, 1'b0);   // variant B, emulation, stalls
      run(3, 12, 1'b0, 2'd1, 1, 1'b1);   // prototype, sub-window, go while busy
      run(5, 5, 1'b0, 2'd2, 0, 1'b0);    // R8 empty window
      run(10, 4, 1'b1, 2'd2, 0, 1'b0);   // R8 start above end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule